// File: doc/BRIEF.md
# AHB Subordinate to TileLink-UL Manager Bridge

This block sits on an AHB bus as a subordinate and forwards every accepted AHB transfer as exactly one TileLink Uncached Lightweight transaction on its manager port. Only one TileLink transaction is in flight at a time. The AHB data phase is stretched with HREADYOUT low until the matching D response comes back. The bridge then returns the read data, or a completion status, within that same data phase.

A small state machine controls the transfer in four steps: capture, request, wait and respond. A read can go out on the A channel in the first data-phase cycle. A write spends one extra cycle collecting HWDATA before its A packet is formed. If the D response reports denial or corruption, the bridge answers with the two-cycle AHB ERROR sequence. The bridge fills in the TileLink size and byte mask from HSIZE and the low address bits. A fixed source ID is used for every request.

Top module: `ahb2tlul_bridge`

## Requirements
- R1: After reset, hreadyout is 1, hresp is 0, tl_a_valid is 0 and tl_d_ready is 0.
- R2: A cycle is an accepted address phase only when hsel, hready and a NONSEQ (2'b10) or SEQ (2'b11) htrans are all high. An IDLE (2'b00) or BUSY (2'b01) htrans, a low hsel or a low hready gets a zero-wait OKAY response: hreadyout stays 1, hresp stays 0 and no A packet is issued.
- R3: A read raises tl_a_valid in the first data-phase cycle, with opcode Get (3'd4), tl_a_address equal to the captured haddr and tl_a_size equal to the captured hsize.
- R4: A write raises tl_a_valid one cycle later, in the second data-phase cycle. tl_a_data equals the hwdata present in the first data-phase cycle. The opcode is PutFullData (3'd0) when hsize equals log2 of the bus byte count, and PutPartialData (3'd1) otherwise.
- R5: Bit b of tl_a_mask is 1 exactly when (b >> hsize) equals (haddr[OFF_W-1:0] >> hsize). The mask is never zero.
- R6: While tl_a_valid is high and tl_a_ready is low, tl_a_valid stays high and the address, opcode and mask do not change.
- R7: hreadyout is 0 from the first data-phase cycle until the D response is accepted. tl_d_ready rises only after the A packet has been accepted. For a clean response, the cycle after acceptance shows hreadyout 1, hresp 0 and hrdata equal to tl_d_data.
- R8: A D response with tl_d_denied or tl_d_corrupt set gives hresp 1 with hreadyout 0 for one cycle, then hresp 1 with hreadyout 1.
- R9: tl_a_valid and tl_d_ready are never high together, and tl_a_source always equals SRC_ID.
- R10: An address phase presented in a completion cycle (OKAY or the second ERROR cycle) is accepted without extra idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hsel | input | 1 | Subordinate select |
| haddr | input | ADDR_W | Transfer address |
| htrans | input | 2 | Transfer type |
| hwrite | input | 1 | 1 for write |
| hsize | input | 3 | log2 of transfer bytes |
| hwdata | input | DATA_W | Write data |
| hready | input | 1 | Bus-wide ready |
| hreadyout | output | 1 | Subordinate ready |
| hresp | output | 1 | 1 for ERROR |
| hrdata | output | DATA_W | Read data |
| tl_a_valid | output | 1 | A channel valid |
| tl_a_ready | input | 1 | A channel ready |
| tl_a_opcode | output | 3 | Get / PutFullData / PutPartialData |
| tl_a_size | output | 3 | log2 of request bytes |
| tl_a_source | output | SRC_W | Source ID |
| tl_a_address | output | ADDR_W | Request address |
| tl_a_mask | output | DATA_W/8 | Byte lane mask |
| tl_a_data | output | DATA_W | Write data |
| tl_d_valid | input | 1 | D channel valid |
| tl_d_ready | output | 1 | D channel ready |
| tl_d_denied | input | 1 | Request denied |
| tl_d_corrupt | input | 1 | Data corrupt |
| tl_d_data | input | DATA_W | Read data |

## Verification
A wrong control state becomes visible at the ports within one cycle of the transfer. The symptoms are an A packet appearing a cycle early or late for a write, tl_d_ready rising while tl_a_valid is still waiting, or hreadyout rising before the D handshake. A corrupted capture register shows up as the wrong address, mask, opcode or data on the A channel in the cycle the request first becomes valid. A broken error path either drops the first ERROR cycle or never completes. Both cases appear within two cycles of the D handshake.

// File: rtl/ahb2tlul_bridge.sv
module ahb2tlul_bridge #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 4,
  parameter int SRC_ID = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hsel,
  input  logic [ADDR_W-1:0]   haddr,
  input  logic [1:0]          htrans,
  input  logic                hwrite,
  input  logic [2:0]          hsize,
  input  logic [DATA_W-1:0]   hwdata,
  input  logic                hready,
  output logic                hreadyout,
  output logic                hresp,
  output logic [DATA_W-1:0]   hrdata,
  output logic                tl_a_valid,
  input  logic                tl_a_ready,
  output logic [2:0]          tl_a_opcode,
  output logic [2:0]          tl_a_size,
  output logic [SRC_W-1:0]    tl_a_source,
  output logic [ADDR_W-1:0]   tl_a_address,
  output logic [DATA_W/8-1:0] tl_a_mask,
  output logic [DATA_W-1:0]   tl_a_data,
  input  logic                tl_d_valid,
  output logic                tl_d_ready,
  input  logic                tl_d_denied,
  input  logic                tl_d_corrupt,
  input  logic [DATA_W-1:0]   tl_d_data
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);
  localparam logic [2:0] OP_GET  = 3'd4;
  localparam logic [2:0] OP_FULL = 3'd0;
  localparam logic [2:0] OP_PART = 3'd1;

  typedef enum logic [2:0] {S_IDLE, S_WDAT, S_REQ, S_RESP, S_ERR1, S_ERR2} st_t;
  st_t st;

  logic [ADDR_W-1:0] addr_q;
  logic [2:0]        size_q;
  logic              wr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  wire open_slot = (st == S_IDLE) || (st == S_ERR2);
  wire take = open_slot && hsel && hready && (htrans == 2'b10 || htrans == 2'b11);
  wire full = {29'd0, size_q} >= OFF_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st)
        S_IDLE, S_ERR2: begin
          st <= S_IDLE;
          if (take) begin
            addr_q <= haddr;
            size_q <= hsize;
            wr_q   <= hwrite;
            st     <= hwrite ? S_WDAT : S_REQ;
          end
        end
        S_WDAT: begin
          wdata_q <= hwdata;
          st      <= S_REQ;
        end
        S_REQ:  if (tl_a_ready) st <= S_RESP;
        S_RESP: if (tl_d_valid) begin
          rdata_q <= tl_d_data;
          st      <= (tl_d_denied || tl_d_corrupt) ? S_ERR1 : S_IDLE;
        end
        S_ERR1: st <= S_ERR2;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    for (int b = 0; b < BYTES; b++)
      tl_a_mask[b] = (OFF_W'(b) >> size_q) == (addr_q[OFF_W-1:0] >> size_q);
  end

  assign hreadyout    = open_slot;
  assign hresp        = (st == S_ERR1) || (st == S_ERR2);
  assign hrdata       = rdata_q;
  assign tl_a_valid   = (st == S_REQ);
  assign tl_d_ready   = (st == S_RESP);
  assign tl_a_opcode  = !wr_q ? OP_GET : (full ? OP_FULL : OP_PART);
  assign tl_a_size    = size_q;
  assign tl_a_source  = SRC_W'(SRC_ID);
  assign tl_a_address = addr_q;
  assign tl_a_data    = wdata_q;
endmodule

// File: rtl/ahb2tlul_bridge_chk.sv
module ahb2tlul_bridge_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SRC_W  = 4,
  parameter int SRC_ID = 0
) (
  input logic                clk,
  input logic                rst_n,
  input logic                hreadyout,
  input logic                hresp,
  input logic                tl_a_valid,
  input logic                tl_a_ready,
  input logic [2:0]          tl_a_opcode,
  input logic [SRC_W-1:0]    tl_a_source,
  input logic [ADDR_W-1:0]   tl_a_address,
  input logic [DATA_W/8-1:0] tl_a_mask,
  input logic                tl_d_valid,
  input logic                tl_d_ready,
  input logic                tl_d_denied,
  input logic                tl_d_corrupt
);
  AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tl_a_valid && !tl_a_ready |=> tl_a_valid && $stable(tl_a_address) && $stable(tl_a_opcode) && $stable(tl_a_mask)); // R6
  AST_MASK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tl_a_valid |-> tl_a_mask != '0); // R5
  AST_STALL_DURING_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tl_a_valid || tl_d_ready) |-> !hreadyout); // R7
  AST_CLEAN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    tl_d_valid && tl_d_ready && !tl_d_denied && !tl_d_corrupt |=> hreadyout && !hresp); // R7
  AST_ERR_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    tl_d_valid && tl_d_ready && (tl_d_denied || tl_d_corrupt) |=> hresp && !hreadyout); // R8
  AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    hresp && !hreadyout |=> hresp && hreadyout); // R8
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(tl_a_valid && tl_d_ready)); // R9
  AST_FIXED_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    tl_a_valid |-> tl_a_source == SRC_W'(SRC_ID)); // R9
endmodule

bind ahb2tlul_bridge ahb2tlul_bridge_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SRC_W(SRC_W), .SRC_ID(SRC_ID)
) u_chk (.*);

// File: tb/ahb2tlul_bridge_tb.sv
module ahb2tlul_bridge_tb;
  localparam int AW = 32, DW = 32, SW = 4, SID = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic hsel = 0, hwrite = 0, hr_hold = 0;
  logic [AW-1:0] haddr = '0;
  logic [1:0] htrans = 2'b00;
  logic [2:0] hsize = 3'd0;
  logic [DW-1:0] hwdata = '0, hrdata, tl_a_data, tl_d_data = '0;
  logic hreadyout, hresp, hready;
  logic tl_a_valid, tl_a_ready = 0, tl_d_valid = 0, tl_d_ready, tl_d_denied = 0, tl_d_corrupt = 0;
  logic [2:0] tl_a_opcode, tl_a_size;
  logic [SW-1:0] tl_a_source;
  logic [AW-1:0] tl_a_address;
  logic [DW/8-1:0] tl_a_mask;

  assign hready = hreadyout & ~hr_hold;

  ahb2tlul_bridge #(.ADDR_W(AW), .DATA_W(DW), .SRC_W(SW), .SRC_ID(SID)) u_dut (.*);

  int checks = 0, errors = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [2:0] sz,
                      input logic [DW-1:0] wd, input int adly, input int ddly,
                      input logic den, input logic cor);
    logic [3:0] exp_mask;
    logic [2:0] exp_op;
    logic [DW-1:0] rd;
    exp_mask = 4'(((1 << (1 << sz)) - 1) << (a[1:0]));
    exp_op = !wr ? 3'd4 : (sz == 3'd2 ? 3'd0 : 3'd1);
    rd = a ^ 32'hA5C3_0000 ^ {29'd0, sz};
    chk("R10 open slot hreadyout", {63'd0, hreadyout}, 64'd1);
    hsel = 1; htrans = 2'b10; haddr = a; hwrite = wr; hsize = sz;
    @(negedge clk);
    hsel = 0; htrans = 2'b00; hwdata = wd;
    chk("R7 stall first data cycle", {63'd0, hreadyout}, 64'd0);
    if (wr) begin
      chk("R4 no A packet before data", {63'd0, tl_a_valid}, 64'd0);
      @(negedge clk);
      hwdata = ~wd;
    end
    for (int i = 0; i <= adly; i++) begin
      chk(wr ? "R4 A valid" : "R3 A valid", {63'd0, tl_a_valid}, 64'd1);
      chk("R3 address", {32'd0, tl_a_address}, {32'd0, a});
      chk("R3 size", {61'd0, tl_a_size}, {61'd0, sz});
      chk(wr ? "R4 opcode" : "R3 opcode", {61'd0, tl_a_opcode}, {61'd0, exp_op});
      chk("R5 mask", {60'd0, tl_a_mask}, {60'd0, exp_mask});
      chk("R9 source", {60'd0, tl_a_source}, 64'(SID));
      chk("R9 no d_ready while A pending", {63'd0, tl_d_ready}, 64'd0);
      if (wr) chk("R4 write data", {32'd0, tl_a_data}, {32'd0, wd});
      if (i == adly) tl_a_ready = 1;
      @(negedge clk);
    end
    tl_a_ready = 0;
    for (int i = 0; i <= ddly; i++) begin
      chk("R7 d_ready after A", {62'd0, tl_a_valid, tl_d_ready}, 64'd1);
      chk("R7 stall while waiting", {63'd0, hreadyout}, 64'd0);
      if (i == ddly) begin
        tl_d_valid = 1; tl_d_data = rd; tl_d_denied = den; tl_d_corrupt = cor;
      end
      @(negedge clk);
    end
    tl_d_valid = 0; tl_d_denied = 0; tl_d_corrupt = 0; tl_d_data = '0;
    if (den || cor) begin
      chk("R8 error first cycle", {62'd0, hresp, hreadyout}, 64'd2);
      @(negedge clk);
      chk("R8 error second cycle", {62'd0, hresp, hreadyout}, 64'd3);
    end else begin
      chk("R7 okay done", {62'd0, hresp, hreadyout}, 64'd1);
      if (!wr) chk("R7 read data", {32'd0, hrdata}, {32'd0, rd});
    end
  endtask

  task automatic ignored(input logic s, input logic [1:0] t, input logic hold);
    hsel = s; htrans = t; haddr = 32'h40; hwrite = 0; hsize = 3'd2; hr_hold = hold;
    @(negedge clk);
    hsel = 0; htrans = 2'b00; hr_hold = 0;
    for (int k = 0; k < 2; k++) begin
      chk("R2 no A packet", {63'd0, tl_a_valid}, 64'd0);
      chk("R2 zero-wait okay", {62'd0, hresp, hreadyout}, 64'd1);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset state", {60'd0, hreadyout, hresp, tl_a_valid, tl_d_ready}, 64'b1000);
    ignored(1, 2'b00, 0);
    ignored(1, 2'b01, 0);
    ignored(0, 2'b10, 0);
    ignored(1, 2'b10, 1);
    for (int sz = 0; sz < 3; sz++)
      for (int off = 0; off < 4; off += (1 << sz))
        for (int wr = 0; wr < 2; wr++)
          xfer(wr[0], 32'h1000 + 32'(off) + 32'(sz * 16), 3'(sz),
               32'h1234_5678 ^ 32'(off * 257 + sz), (off + wr) % 3, sz, 0, 0);
    xfer(0, 32'h2000, 3'd2, '0, 0, 0, 1, 0);
    xfer(1, 32'h2004, 3'd2, 32'hCAFE_F00D, 1, 0, 0, 1);
    xfer(0, 32'h2008, 3'd1, '0, 0, 2, 1, 1);
    xfer(1, 32'h3003, 3'd0, 32'h0000_00AB, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule